// File: doc/BRIEF.md
# Serial Configuration and Calibration Register Port

This block is the register-access side of a converter's serial interface. A host brackets every transfer with an active-low frame strobe, clocks bits with a serial clock, and picks the target with a one-bit select input. It also states the direction of each frame on a separate request line. The block keeps a 24-bit configuration word and, for each of two channels, a 24-bit zero-scale coefficient and a 24-bit full-scale coefficient. A write only takes effect once a complete 24-bit word has been shifted in. A read streams the addressed contents out MSB first. Conversion results are not produced here: a parallel data word enters from outside, and select-high reads return it in the ordinary modes.

All serial inputs are brought into the system clock domain through synchronizers, and their edges are detected there. A six-state machine handles framing. Its states are IDLE, WR_SHIFT, WR_FULL, RD_LOAD, RD_SHIFT and RD_DONE. The named transitions are:
- frame start: IDLE to WR_SHIFT, or IDLE to RD_LOAD.
- word complete: WR_SHIFT to WR_FULL.
- load done: RD_LOAD to RD_SHIFT.
- word sent: RD_SHIFT to RD_DONE.
- frame end: any state to IDLE.

Top module: `scp_top`

## Requirements
- R1: When `sel` is 0, a write frame targets the configuration word and a read frame returns that word, 24 bits long.
- R2: A write frame that ends before 24 bits have arrived leaves its target unchanged. This applies to the configuration word and to both coefficient sets.
- R3: Serial clock pulses after the 24th in a write frame have no effect. Read frames send 0 on `sdo` once the word has been fully sent.
- R4: The bit count restarts at zero in every frame. A short frame has no effect on how the next frame is counted.
- R5: The configuration word layout, given as bit positions with 23 as the MSB, is:
  - mode: [23:21]
  - gain: [20:18]
  - channel: [17]
  - power-down: [16]
  - word length: [15]
  - spare: [14]
  - burnout: [13]
  - polarity: [12]
  - filter: [11:0]

  The word appears unchanged on `cfg_word`.
- R6: When the mode field is 3'b110, a select-high frame reads or writes the zero-scale coefficient of the channel given by bit 17.
- R7: When the mode field is 3'b111, a select-high frame reads or writes the full-scale coefficient of the channel given by bit 17.
- R8: In any other mode, a select-high read returns `data_in`. It returns all 24 bits when bit 15 is 1, and only `data_in[23:8]` followed by zeros when bit 15 is 0. Select-high writes in these modes change nothing.
- R9: Coefficient reads and writes are always 24 bits long, whatever the value of bit 15.
- R10: After reset, the configuration word is 0, so the mode is 3'b000. The zero-scale coefficients are 0, the full-scale coefficients are 24'h800000, and `sdo` is 0.
- R11: `sdi` is captured on rising `sclk` edges, MSB first. `sdo` advances after falling `sclk` edges. The first bit is presented once the frame opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| frame_n | input | 1 | Active-low frame strobe |
| rd_req | input | 1 | Frame direction: 1 read, 0 write |
| sel | input | 1 | Target select: 0 configuration word, 1 mode-dependent |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| data_in | input | 24 | Conversion data word supplied from outside |
| cfg_word | output | 24 | Current configuration word |

## Verification
Each serial edge reaches the state machine three system clocks after it occurs: two synchronizer stages and one edge-detect register. A committed write therefore shows up on `cfg_word` about five clocks after the 24th rising edge. A new `sdo` bit settles about four clocks after a falling edge. The bench holds each `sclk` level for six clocks and samples `sdo` just before driving the next rising edge. After a frame closes it waits eight clocks before it compares `cfg_word` or opens the next frame. Every read pulls 32 bits, so the zero tail after the word is checked in the same stream.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SHIFT,
        ST_WR_FULL,
        ST_RD_LOAD,
        ST_RD_SHIFT,
        ST_RD_DONE
    } state_t;

    typedef enum logic [1:0] {
        TGT_CTRL,
        TGT_ZERO,
        TGT_FULL,
        TGT_DATA
    } tgt_t;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_ZERO_COEF = 3'b110;
    localparam mode_t MODE_FULL_COEF = 3'b111;

    function automatic tgt_t pick_target(input logic sel, input mode_t mode);
        if (!sel)
            return TGT_CTRL;
        else if (mode == MODE_ZERO_COEF)
            return TGT_ZERO;
        else if (mode == MODE_FULL_COEF)
            return TGT_FULL;
        else
            return TGT_DATA;
    endfunction

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int          W       = 5,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/scp_serial_fsm.sv
module scp_serial_fsm
    import scp_pkg::*;
#(
    parameter int W       = 24,
    parameter int SHORT_W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         frame_low,
    input  logic         frame_fall,
    input  logic         sdi,
    input  logic         rd_req,
    input  logic         sel,
    input  mode_t        mode,
    input  logic         wl,
    input  logic [W-1:0] rd_word,
    output logic         sdo,
    output logic         wr_en,
    output tgt_t         wr_tgt,
    output logic [W-1:0] wr_data,
    output tgt_t         rd_tgt
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    state_t            state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  len_q;
    logic [W-1:0]      shreg_q;
    tgt_t              tgt_q;
    logic              wr_en_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (!frame_low) begin
            state_d = ST_IDLE;                       // frame end
        end else begin
            unique case (state_q)
                ST_IDLE:     if (frame_fall) state_d = rd_req ? ST_RD_LOAD : ST_WR_SHIFT;
                ST_WR_SHIFT: if (sclk_rise && cnt_q == LAST) state_d = ST_WR_FULL;
                ST_WR_FULL:  state_d = ST_WR_FULL;
                ST_RD_LOAD:  state_d = ST_RD_SHIFT;
                ST_RD_SHIFT: if (sclk_fall && cnt_q == len_q - CNT_W'(1)) state_d = ST_RD_DONE;
                ST_RD_DONE:  state_d = ST_RD_DONE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            len_q   <= CNT_W'(W);
            shreg_q <= '0;
            tgt_q   <= TGT_CTRL;
            wr_en_q <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (frame_low && frame_fall) tgt_q <= pick_target(sel, mode);
                end
                ST_WR_SHIFT: begin
                    if (sclk_rise) begin
                        shreg_q <= {shreg_q[W-2:0], sdi};
                        cnt_q   <= cnt_q + CNT_W'(1);
                        if (cnt_q == LAST) wr_en_q <= 1'b1;
                    end
                end
                ST_RD_LOAD: begin
                    shreg_q <= rd_word;
                    cnt_q   <= '0;
                    len_q   <= (tgt_q == TGT_DATA && !wl) ? CNT_W'(SHORT_W) : CNT_W'(W);
                end
                ST_RD_SHIFT: begin
                    if (sclk_fall) begin
                        shreg_q <= {shreg_q[W-2:0], 1'b0};
                        cnt_q   <= cnt_q + CNT_W'(1);
                    end
                end
                ST_WR_FULL, ST_RD_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo     = (state_q == ST_RD_SHIFT) ? shreg_q[W-1] : 1'b0;
        wr_en   = wr_en_q;
        wr_data = shreg_q;
        wr_tgt  = tgt_q;
        rd_tgt  = tgt_q;
    end

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(W));
    a_r4_idle_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_low |=> state_q == ST_IDLE);
    a_r2_commit_needs_full_word: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |-> cnt_q == CNT_W'(W));
    a_r1_commit_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_q |=> !wr_en_q);
    a_r11_sdo_quiet_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RD_SHIFT) |-> !sdo);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int          W         = 24,
    parameter int          NUM_CH    = 2,
    parameter int          CH_BIT    = 17,
    parameter logic [W-1:0] FULL_INIT = 24'h800000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  tgt_t         wr_tgt,
    input  logic [W-1:0] wr_data,
    input  tgt_t         rd_tgt,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] rd_word,
    output logic [W-1:0] ctrl_word
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [W-1:0]    ctrl_q;
    logic [W-1:0]    zero_q [NUM_CH];
    logic [W-1:0]    full_q [NUM_CH];
    logic [CH_W-1:0] chan;

    assign chan = ctrl_q[CH_BIT +: CH_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             ctrl_q <= '0;
        else if (wr_en && wr_tgt == TGT_CTRL)   ctrl_q <= wr_data;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                zero_q[ch] <= '0;
                full_q[ch] <= FULL_INIT;
            end else if (wr_en && chan == CH_W'(ch)) begin
                if (wr_tgt == TGT_ZERO) zero_q[ch] <= wr_data;
                if (wr_tgt == TGT_FULL) full_q[ch] <= wr_data;
            end
        end

        a_r6_zero_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(zero_q[ch]) |-> $past(wr_en && wr_tgt == TGT_ZERO));
        a_r7_full_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(full_q[ch]) |-> $past(wr_en && wr_tgt == TGT_FULL));
    end

    always_comb begin
        unique case (rd_tgt)
            TGT_CTRL: rd_word = ctrl_q;
            TGT_ZERO: rd_word = zero_q[chan];
            TGT_FULL: rd_word = full_q[chan];
            default:  rd_word = data_in;
        endcase
    end

    assign ctrl_word = ctrl_q;

    a_r2_ctrl_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> $past(wr_en && wr_tgt == TGT_CTRL));
endmodule

// File: rtl/scp_top.sv
module scp_top
    import scp_pkg::*;
#(
    parameter int          WORD_W      = 24,
    parameter int          SHORT_W     = 16,
    parameter int          NUM_CH      = 2,
    parameter int          SYNC_STAGES = 2,
    parameter logic [WORD_W-1:0] FULL_INIT = 24'h800000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              frame_n,
    input  logic              rd_req,
    input  logic              sel,
    input  logic              sdi,
    output logic              sdo,
    input  logic [WORD_W-1:0] data_in,
    output logic [WORD_W-1:0] cfg_word
);
    localparam int MODE_HI = WORD_W - 1;
    localparam int CH_BIT  = WORD_W - 7;
    localparam int WL_BIT  = WORD_W - 9;

    logic [4:0]        raw_in, syn;
    logic [1:0]        prev_q;
    logic              wr_en;
    tgt_t              wr_tgt, rd_tgt;
    logic [WORD_W-1:0] wr_data, rd_word, ctrl_word;

    assign raw_in = {rd_req, sel, sdi, frame_n, sclk};

    scp_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00010)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b10;
        else        prev_q <= syn[1:0];
    end

    scp_serial_fsm #(.W(WORD_W), .SHORT_W(SHORT_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .sclk_rise(syn[0] && !prev_q[0]),
        .sclk_fall(!syn[0] && prev_q[0]),
        .frame_low(!syn[1]),
        .frame_fall(!syn[1] && prev_q[1]),
        .sdi(syn[2]), .rd_req(syn[4]), .sel(syn[3]),
        .mode(ctrl_word[MODE_HI -: 3]), .wl(ctrl_word[WL_BIT]),
        .rd_word(rd_word), .sdo(sdo),
        .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data), .rd_tgt(rd_tgt)
    );

    scp_regfile #(.W(WORD_W), .NUM_CH(NUM_CH), .CH_BIT(CH_BIT), .FULL_INIT(FULL_INIT)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_tgt(wr_tgt), .wr_data(wr_data),
        .rd_tgt(rd_tgt), .data_in(data_in),
        .rd_word(rd_word), .ctrl_word(ctrl_word)
    );

    assign cfg_word = ctrl_word;
endmodule

// File: tb/test_scp_top.sv
module test_scp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, frame_n = 1'b1, rd_req = 1'b0, sel = 1'b0, sdi = 1'b0;
    logic        sdo;
    logic [23:0] data_in = 24'h0;
    logic [23:0] cfg_word;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [23:0] m_ctrl;
    logic [23:0] m_zero [2];
    logic [23:0] m_full [2];

    always #10 clk = ~clk;   // 50 MHz

    scp_top i_scp_top (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .frame_n(frame_n), .rd_req(rd_req),
        .sel(sel), .sdi(sdi), .sdo(sdo), .data_in(data_in), .cfg_word(cfg_word)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic int tgt_of(input logic s);
        if (!s) return 0;
        if (m_ctrl[23:21] == 3'b110) return 1;
        if (m_ctrl[23:21] == 3'b111) return 2;
        return 3;
    endfunction

    function automatic logic [31:0] exp_stream(input logic s);
        int ch = int'(m_ctrl[17]);
        unique case (tgt_of(s))
            0: return {m_ctrl, 8'h0};
            1: return {m_zero[ch], 8'h0};
            2: return {m_full[ch], 8'h0};
            default: return m_ctrl[15] ? {data_in, 8'h0} : {data_in[23:8], 16'h0};
        endcase
    endfunction

    task automatic send(input logic s, input logic [31:0] bits, input int n);
        int t = tgt_of(s);
        int ch = int'(m_ctrl[17]);
        rd_req = 1'b0; sel = s; sclk = 1'b0;
        tick(6); frame_n = 1'b0; tick(6);
        for (int i = 0; i < n; i++) begin
            sdi = bits[31-i]; tick(6);
            sclk = 1'b1; tick(6);
            sclk = 1'b0;
        end
        tick(6); frame_n = 1'b1; tick(8);
        if (n >= 24) begin
            unique case (t)
                0: m_ctrl = bits[31:8];
                1: m_zero[ch] = bits[31:8];
                2: m_full[ch] = bits[31:8];
                default: ;
            endcase
        end
    endtask

    task automatic fetch(input logic s, output logic [31:0] got);
        rd_req = 1'b1; sel = s; sclk = 1'b0;
        tick(6); frame_n = 1'b0; tick(8);
        for (int i = 0; i < 32; i++) begin
            got[31-i] = sdo;
            sclk = 1'b1; tick(6);
            sclk = 1'b0; tick(6);
        end
        frame_n = 1'b1; tick(8);
    endtask

    task automatic read_check(input string req, input logic s);
        logic [31:0] g;
        fetch(s, g);
        check(req, g, exp_stream(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h5C0F_1E2D));
        m_ctrl = 24'h0; m_zero[0] = 24'h0; m_zero[1] = 24'h0;
        m_full[0] = 24'h800000; m_full[1] = 24'h800000;
        tick(5); rst_n = 1'b1; tick(5);

        // R10 reset state
        check("R10 cfg", {8'h0, cfg_word}, 32'h0);
        check("R10 sdo", {31'h0, sdo}, 32'h0);
        read_check("R1 R11 ctrl reset read", 1'b0);
        send(1'b0, {24'hC00000, 8'h0}, 24);               // mode 110 ch0
        read_check("R10 zero ch0 reset", 1'b1);
        send(1'b0, {24'hE20000, 8'h0}, 24);               // mode 111 ch1
        read_check("R10 full ch1 reset", 1'b1);

        // R1 R5 full control write
        send(1'b0, {24'h1A5F3C, 8'h0}, 24);
        check("R1 R5 cfg_word", {8'h0, cfg_word}, {8'h0, m_ctrl});
        read_check("R1 R11 ctrl read", 1'b0);

        // R2 partial write ignored
        send(1'b0, {24'hFFFFFF, 8'h0}, 12);
        check("R2 partial ctrl", {8'h0, cfg_word}, 32'h001A5F3C);

        // R4 next frame counts from zero
        send(1'b0, {24'h0ABCDE, 8'h0}, 24);
        check("R4 restart count", {8'h0, cfg_word}, 32'h000ABCDE);

        // R3 extra clocks ignored
        send(1'b0, {24'h03C3A5, 8'hFF}, 30);
        check("R3 extra clocks", {8'h0, cfg_word}, 32'h0003C3A5);

        // R6 zero-scale per channel, wl=0 -> R9 24-bit
        send(1'b0, {24'hC00000, 8'h0}, 24);
        send(1'b1, {24'h123456, 8'h0}, 24);
        send(1'b0, {24'hC20000, 8'h0}, 24);
        send(1'b1, {24'h654321, 8'h0}, 24);
        read_check("R6 R9 zero ch1", 1'b1);
        send(1'b0, {24'hC00000, 8'h0}, 24);
        read_check("R6 zero ch0", 1'b1);
        send(1'b1, {24'hABCDEF, 8'h0}, 20);
        read_check("R2 R9 partial coef", 1'b1);

        // R7 full-scale
        send(1'b0, {24'hE00000, 8'h0}, 24);
        send(1'b1, {24'h7F00FF, 8'h0}, 27);
        read_check("R7 R3 full ch0", 1'b1);

        // R8 data reads
        data_in = 24'hA1B2C3;
        send(1'b0, {24'h008000, 8'h0}, 24);               // mode 000 wl=1
        read_check("R8 data 24-bit", 1'b1);
        send(1'b0, {24'h000000, 8'h0}, 24);               // wl=0
        read_check("R8 data 16-bit", 1'b1);
        send(1'b1, {24'h555555, 8'h0}, 24);               // ignored
        send(1'b0, {24'hC00000, 8'h0}, 24);
        read_check("R8 select-high write ignored", 1'b1);
        send(1'b0, {24'hE00000, 8'h0}, 24);
        read_check("R8 full unchanged", 1'b1);

        // random mix
        for (int k = 0; k < 40; k++) begin
            int op = int'($urandom % 3);
            int n = 20 + int'($urandom % 10);
            w = $urandom;
            if (op == 0) begin
                unique case ($urandom % 4)
                    0: w[31:29] = 3'b110;
                    1: w[31:29] = 3'b111;
                    2: w[31:29] = 3'b000;
                    default: ;
                endcase
                send(1'b0, w, n);
            end else if (op == 1) begin
                send(1'b1, w, n);
            end else begin
                data_in = w[23:0];
            end
            check("R1 R2 R5 random cfg", {8'h0, cfg_word}, {8'h0, m_ctrl});
            read_check("R6 R7 R8 random select-high", 1'b1);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule